// File: doc/BRIEF.md
# Edge-Resynchronising Manchester Word Receiver

This block recovers 16-bit words from a serial line that carries Manchester-coded bits inside a UART-style frame. The line rests high. A frame opens with a start bit, carries the data bits least significant bit first, and closes with a stop bit. Every bit has a transition at its centre. A rising centre edge means one and a falling centre edge means zero. An edge between two bits appears only when it is needed to set up the next centre edge. Start and stop bits are both coded as ones.

The receiver does not time the whole frame from the start edge. It re-anchors its bit timer on each centre edge it accepts. For three quarters of a nominal bit time after that anchor it ignores all edges, so boundary edges are never read as data. The first edge after this blanking window is taken as the next centre edge. A transmitter whose clock differs from the receiver's by about a fifth can therefore still be decoded.

The raw line goes through a two-flop synchroniser, and edges are then detected on the synchronised level. A good word is presented with a one-cycle strobe. A broken frame raises a one-cycle error strobe. After an error the receiver drains until the line has been high for a full bit time.

Top module: `edge_word_rx`

FSM states:
- `ST_IDLE`: the line rests high.
- `ST_START`: waiting for the centre edge of the start bit.
- `ST_DATA`: collecting data bits.
- `ST_STOP`: waiting for the centre edge of the stop bit.
- `ST_DRAIN`: after an error, waiting for the line to be quiet and high.

Transitions:
- IDLE→START on a falling edge.
- START→DATA on a rising edge at least a quarter bit after the falling edge.
- START→IDLE on a rising edge earlier than that (a glitch).
- START→DRAIN on timeout.
- DATA→DATA on each accepted edge.
- DATA→STOP after the last data bit.
- DATA→DRAIN on timeout.
- STOP→IDLE on a rising centre edge (word good).
- STOP→DRAIN on a falling centre edge or on timeout.
- DRAIN→IDLE after one bit time of continuous high.

## Requirements
- R1: After reset, `word_valid` and `frame_err` are 0 and `word_out` is 0.
- R2: A frame is decoded as follows. The start bit comes first, then data bit 0 through bit 15, then the stop bit. A rising centre edge decodes as 1 and a falling centre edge decodes as 0. On a frame sent at the nominal bit time, the decoded value appears on `word_out`.
- R3: Edges that arrive within 3/4 of `BIT_CYCLES` after an accepted centre edge are ignored. Words with runs of equal bits, which carry boundary edges, still decode correctly.
- R4: With `BIT_CYCLES`=16, frames decode correctly at any transmit bit time from 13 to 19 cycles. This holds because the timer re-anchors on every centre edge.
- R5: A good frame produces exactly one `word_valid` pulse, one cycle wide. It is raised only from the stop-bit state, and `word_out` holds its value until the next good frame.
- R6: A stop bit whose centre edge falls produces one `frame_err` pulse and no `word_valid`.
- R7: If no edge is accepted within 3/2 of `BIT_CYCLES` of the last anchor during a frame, one `frame_err` pulse is raised. This covers the line stuck either high or low, and no word is delivered.
- R8: After an error, the receiver waits until the line has been high for `BIT_CYCLES` cycles. A frame that follows is then decoded correctly.
- R9: A low pulse from idle whose rising edge comes less than `BIT_CYCLES`/4 after its falling edge is dropped without `word_valid` or `frame_err`.
- R10: `word_valid` and `frame_err` are never high in the same cycle, and `frame_err` is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw asynchronous Manchester line, high when idle |
| word_out | output | 16 | Last word received without error |
| word_valid | output | 1 | One-cycle strobe: `word_out` has just been updated |
| frame_err | output | 1 | One-cycle strobe: a frame was abandoned |

## Verification
The bench drives the decoder with several kinds of words, each chosen to expose a different fault:
- All-zero and all-one words produce a boundary edge on every bit, so they show whether blanking works.
- Alternating words produce no boundary edges at all, so they show whether the bit order and polarity are right.
- Random words at random bit times between 13 and 19 cycles separate true per-edge re-anchoring from timing that runs freely from the start edge.

Directed frames cover the remaining cases:
- a falling stop bit;
- a line stalled high and a line stalled low in mid-frame;
- a short low glitch from idle.

These show the error and glitch paths apart from the good path, and show that the next frame is recovered afterwards.

// File: rtl/edge_rx_pkg.sv
package edge_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_DRAIN
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev_level;

    // Resets to the idle-high level so that reset release is not seen as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain      <= '1;
            prev_level <= 1'b1;
        end else begin
            chain      <= {chain[STAGES-2:0], line_async};
            prev_level <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev_level;
    assign fall  = ~level & prev_level;

endmodule

// File: rtl/rx_window_timer.sv
module rx_window_timer #(
    parameter int BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic quarter_done,
    output logic blank_done,
    output logic bit_done,
    output logic expired
);

    localparam int QUARTER = BIT_CYCLES / 4;
    localparam int BLANK   = (3 * BIT_CYCLES) / 4;
    localparam int TIMEOUT = (3 * BIT_CYCLES) / 2;
    localparam int CW      = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    // Counts cycles since the last clear and saturates at the timeout.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cnt != CW'(TIMEOUT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign quarter_done = (cnt >= CW'(QUARTER));
    assign blank_done   = (cnt >= CW'(BLANK));
    assign bit_done     = (cnt >= CW'(BIT_CYCLES));
    assign expired      = (cnt == CW'(TIMEOUT));

    // R7
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);

endmodule

// File: rtl/rx_word_shift.sv
module rx_word_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data
);

    // New bits enter at the top, so after WIDTH shifts the first bit sits at bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clear) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {bit_in, data[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/edge_word_rx.sv
module edge_word_rx
    import edge_rx_pkg::*;
#(
    parameter int BIT_CYCLES  = 16,
    parameter int WORD_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid,
    output logic                 frame_err
);

    localparam int BCW = $clog2(WORD_BITS);

    rx_state_t            state, state_nx;
    logic                 lvl, rise, fall, any_edge;
    logic                 quarter_done, blank_done, bit_done, expired;
    logic                 tmr_clr, sh_clr, sh_en, sh_bit;
    logic                 good_ev, err_ev, cnt_clr;
    logic [BCW-1:0]       bit_cnt;
    logic [WORD_BITS-1:0] sh_data;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_in),
        .level      (lvl),
        .rise       (rise),
        .fall       (fall)
    );

    rx_window_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (tmr_clr),
        .quarter_done (quarter_done),
        .blank_done   (blank_done),
        .bit_done     (bit_done),
        .expired      (expired)
    );

    rx_word_shift #(.WIDTH(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clr),
        .shift_en (sh_en),
        .bit_in   (sh_bit),
        .data     (sh_data)
    );

    assign any_edge = rise | fall;
    assign sh_bit   = rise;

    // Next-state logic and event decoding
    always_comb begin
        state_nx = state;
        tmr_clr  = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        cnt_clr  = 1'b0;
        good_ev  = 1'b0;
        err_ev   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall) begin
                    state_nx = ST_START;
                    tmr_clr  = 1'b1;
                    sh_clr   = 1'b1;
                end
            end
            ST_START: begin
                if (rise && !quarter_done) begin
                    state_nx = ST_IDLE;
                end else if (rise) begin
                    state_nx = ST_DATA;
                    tmr_clr  = 1'b1;
                    cnt_clr  = 1'b1;
                end else if (expired) begin
                    state_nx = ST_DRAIN;
                    tmr_clr  = 1'b1;
                    err_ev   = 1'b1;
                end
            end
            ST_DATA: begin
                if (any_edge && blank_done) begin
                    sh_en   = 1'b1;
                    tmr_clr = 1'b1;
                    if (bit_cnt == BCW'(WORD_BITS - 1)) begin
                        state_nx = ST_STOP;
                    end
                end else if (expired) begin
                    state_nx = ST_DRAIN;
                    tmr_clr  = 1'b1;
                    err_ev   = 1'b1;
                end
            end
            ST_STOP: begin
                if (rise && blank_done) begin
                    state_nx = ST_IDLE;
                    good_ev  = 1'b1;
                end else if ((fall && blank_done) || expired) begin
                    state_nx = ST_DRAIN;
                    tmr_clr  = 1'b1;
                    err_ev   = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!lvl) begin
                    tmr_clr = 1'b1;
                end else if (bit_done) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // State register and data-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (cnt_clr) begin
                bit_cnt <= '0;
            end else if (sh_en) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            word_valid <= good_ev;
            frame_err  <= err_ev;
            if (good_ev) begin
                word_out <= sh_data;
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(state) == ST_STOP));

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && frame_err));

    // R3
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !blank_done) |=> $stable(sh_data));

    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA || state == ST_STOP) && expired && !any_edge)
            |=> (state == ST_DRAIN && frame_err));

    // R9
    glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && rise && !quarter_done) |=> (state == ST_IDLE && !frame_err));

endmodule

// File: tb/sim_edge_word_rx.sv
`timescale 1ns/1ps
module sim_edge_word_rx;

    localparam int BITC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic [15:0] word;
    logic        vld, err;

    int checks = 0;
    int fails = 0;
    int vcnt = 0;
    int ecnt = 0;
    int wide = 0;
    int both = 0;
    logic        vprev = 1'b0;
    logic        eprev = 1'b0;
    logic [15:0] last_word = '0;

    always #2 clk = ~clk;

    edge_word_rx #(.BIT_CYCLES(BITC), .WORD_BITS(16), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line),
        .word_out   (word),
        .word_valid (vld),
        .frame_err  (err)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vld) begin
                vcnt++;
                last_word = word;
            end
            if (err) ecnt++;
            if ((vld && vprev) || (err && eprev)) wide++;
            if (vld && err) both++;
            vprev = vld;
            eprev = err;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // The line level in the first half of a bit is the inverse of the bit value.
    function automatic logic first_half(logic b);
        return ~b;
    endfunction

    function automatic int stop_bit_of(logic good);
        return good ? 1 : 0;
    endfunction

    task automatic hold(logic v, int n);
        line = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(logic b, int h1, int h2);
        hold(first_half(b), h1);
        hold(b, h2);
    endtask

    task automatic send_frame(logic [15:0] w, int h1, int h2, logic stop_ok);
        send_bit(1'b1, h1, h2);
        for (int i = 0; i < 16; i++) send_bit(w[i], h1, h2);
        send_bit(1'(stop_bit_of(stop_ok)), h1, h2);
        hold(1'b1, 4 * BITC);
    endtask

    task automatic good_frame(string req, logic [15:0] w, int h1, int h2);
        int v0, e0;
        v0 = vcnt;
        e0 = ecnt;
        send_frame(w, h1, h2, 1'b1);
        check({req, " valid count"}, vcnt - v0, 1);
        check({req, " word"}, last_word, w);
        check({req, " no error"}, ecnt - e0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v0, e0, tot, h1;
        logic [15:0] w;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check("R1 valid", vld, 0);
        check("R1 err", err, 0);
        check("R1 word", word, 0);
        hold(1'b1, 2 * BITC);

        // R2 / R3 directed words at nominal timing
        good_frame("R3 all zero", 16'h0000, 8, 8);
        good_frame("R3 all one", 16'hFFFF, 8, 8);
        good_frame("R2 alt A", 16'hAAAA, 8, 8);
        good_frame("R2 alt 5", 16'h5555, 8, 8);
        good_frame("R2 lsb first", 16'h0001, 8, 8);

        // R5 word held, pulses one cycle
        hold(1'b1, 3 * BITC);
        check("R5 word held", word, 16'h0001);

        // R4 clock mismatch corners
        good_frame("R4 slow", 16'hC3A5, 10, 9);
        good_frame("R4 fast", 16'h3C5A, 6, 7);

        // R2 / R4 random words and random bit times
        for (int k = 0; k < 24; k++) begin
            w   = 16'($urandom);
            tot = $urandom_range(19, 13);
            h1  = tot / 2;
            good_frame("R4 random", w, h1, tot - h1);
        end

        // R6 bad stop bit
        v0 = vcnt;
        e0 = ecnt;
        send_frame(16'h1234, 8, 8, 1'b0);
        check("R6 err count", ecnt - e0, 1);
        check("R6 no valid", vcnt - v0, 0);

        // R8 recovery after stop error
        good_frame("R8 after stop err", 16'hBEEF, 8, 8);

        // R7 stall high mid-frame
        v0 = vcnt;
        e0 = ecnt;
        send_bit(1'b1, 8, 8);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 8, 8);
        hold(1'b1, 4 * BITC);
        check("R7 stall high err", ecnt - e0, 1);
        check("R7 stall high no valid", vcnt - v0, 0);
        good_frame("R8 after high stall", 16'h8001, 8, 8);

        // R7 stall low mid-frame
        v0 = vcnt;
        e0 = ecnt;
        send_bit(1'b1, 8, 8);
        send_bit(1'b1, 8, 8);
        send_bit(1'b0, 8, 8);
        hold(1'b0, 3 * BITC);
        hold(1'b1, 4 * BITC);
        check("R7 stall low err", ecnt - e0, 1);
        check("R7 stall low no valid", vcnt - v0, 0);
        good_frame("R8 after low stall", 16'h7FFE, 8, 8);

        // R9 short glitch from idle
        v0 = vcnt;
        e0 = ecnt;
        hold(1'b0, 2);
        hold(1'b1, 4 * BITC);
        check("R9 glitch no valid", vcnt - v0, 0);
        check("R9 glitch no err", ecnt - e0, 0);
        check("R9 word untouched", word, 16'h7FFE);
        good_frame("R9 after glitch", 16'h0F0F, 8, 8);

        // R5 / R10 strobe shape over the whole run
        check("R5 R10 strobe width", wide, 0);
        check("R10 exclusive", both, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule